// File: doc/BRIEF.md
# Frame-Latched Window Configuration Bank

This block holds the per-window configuration of a display controller with five overlay windows. Software writes land in a front copy of every register at once. The copy that the display pipeline sees is the active copy. A window's front values move into its active copy only on a vertical sync pulse. Until that pulse, a partly written set of window values never reaches the pipeline.

Each window has a protect bit that holds back its transfer at vsync. Software can set protect and spread an update over many writes. It then clears protect, and the whole set moves at the next vsync. A shared gate register holds the protect bits next to a per-window channel-enable bit. A run register holds two video-enable bits. One acts at once. The other is latched at vsync, so video output starts on a frame boundary.

Top module: `shadow_bank`

## Requirements
- R1: A synchronous active-high reset clears all front and active values, the gate register, both run bits and `video_run`. Every address then reads zero.
- R2: A write to a window register (address w*4+i, with w from 0 to 4 and i from 0 to 3) changes the front value from the next cycle on. The active outputs do not change without a vsync pulse.
- R3: A vsync pulse copies all four front values of each window whose protect bit is clear into its active slot. The new values appear on `act_regs` in the cycle after the pulse. Window w register i sits at bits [(w*4+i)*32 +: 32].
- R4: A window whose protect bit is set at the vsync edge keeps its active values. Pending front values move at the first vsync after the protect bit is cleared.
- R5: The gate register is at address 21. Bit 2w is the protect bit of window w and bit 2w+1 is its channel-enable bit. `win_protect` and `win_chan_en` follow a write in the next cycle, whether or not vsync is present. A vsync uses the protect value held before its edge.
- R6: Reads are combinational on `addr` and return front values. This holds for window registers and for the gate and run registers, never for active values.
- R7: When a write and vsync fall in the same cycle, the active slot takes the previous front value. The newly written value moves at the following vsync.
- R8: The run register is at address 20. Bit 0 is the immediate enable and bit 1 is the frame-latched enable. `video_run` rises only in the cycle after a vsync at which both bits were set. Clearing bit 0 drops `video_run` in the cycle after the write. Clearing bit 1 drops it after the next vsync.
- R9: Addresses 22 to 31 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (front values) |
| vsync | input | 1 | One-cycle vertical sync pulse |
| act_regs | output | 640 | Active values of all windows |
| win_protect | output | 5 | Per-window protect bits |
| win_chan_en | output | 5 | Per-window channel-enable bits |
| video_run | output | 1 | Video output enable |

## Verification
The bench tries the transfer under every one of the 32 protect masks. Each mask comes with a fresh data pattern per window and register, which shows whether a held window stays held and whether an open window moves all of its registers. Writes without vsync and writes coinciding with vsync separate front from active timing. Run-register sequences cover frame-only, immediate-only and both bits set, which shows whether the start waits for a frame and whether the stop is immediate. Unmapped-address writes followed by full readback show that nothing is touched.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_WIN,
        SEL_RUN,
        SEL_GATE
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [7:0] win;
        logic [7:0] idx;
    } addr_dec_t;

    localparam int RUN_NOW_BIT   = 0;
    localparam int RUN_FRAME_BIT = 1;

    function automatic addr_dec_t decode_addr(input int unsigned a,
                                              input int unsigned nwin,
                                              input int unsigned nreg);
        addr_dec_t d;
        d.kind = SEL_NONE;
        d.win  = '0;
        d.idx  = '0;
        if (a < nwin * nreg) begin
            d.kind = SEL_WIN;
            d.win  = 8'(a / nreg);
            d.idx  = 8'(a % nreg);
        end else if (a == nwin * nreg) begin
            d.kind = SEL_RUN;
        end else if (a == nwin * nreg + 1) begin
            d.kind = SEL_GATE;
        end
        return d;
    endfunction

    function automatic int prot_pos(input int w);
        return 2 * w;
    endfunction

    function automatic int chen_pos(input int w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/sb_addr_decode.sv
module sb_addr_decode
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN      = 5,
    parameter int REGS_PER_WIN = 4,
    parameter int ADDR_W       = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_dec_t         dec
);
    logic [31:0] addr_ext;

    always_comb begin
        addr_ext = {{(32-ADDR_W){1'b0}}, addr};
        dec = decode_addr(addr_ext, NUM_WIN, REGS_PER_WIN);
    end
endmodule

// File: rtl/sb_window_slot.sv
module sb_window_slot #(
    parameter int REGS   = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_hit,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   vsync,
    input  logic                   protect,
    output logic [REGS*DATA_W-1:0] front_o,
    output logic [REGS*DATA_W-1:0] active_o
);
    logic xfer;
    assign xfer = vsync && !protect;

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        logic [DATA_W-1:0] front_q;
        logic [DATA_W-1:0] act_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                front_q <= '0;
            end else if (wr_hit && (wr_idx == IDX_W'(r))) begin
                front_q <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q <= '0;
            end else if (xfer) begin
                act_q <= front_q;
            end
        end

        assign front_o[r*DATA_W +: DATA_W]  = front_q;
        assign active_o[r*DATA_W +: DATA_W] = act_q;
    end
endmodule

// File: rtl/sb_gate_ctrl.sv
module sb_gate_ctrl
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gate_wr,
    input  logic [2*NUM_WIN-1:0] gate_wdata,
    input  logic                 run_wr,
    input  logic [1:0]           run_wdata,
    input  logic                 vsync,
    output logic [NUM_WIN-1:0]   prot,
    output logic [NUM_WIN-1:0]   chen,
    output logic                 video_run,
    output logic [DATA_W-1:0]    gate_word,
    output logic [DATA_W-1:0]    run_word
);
    logic [2*NUM_WIN-1:0] gate_q;
    logic [1:0]           run_q;
    logic                 act_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else if (gate_wr) begin
            gate_q <= gate_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (run_wr) begin
            run_q <= run_wdata;
        end
    end

    // Start waits for a frame boundary; losing the immediate bit
    // forgets the latched start so a restart waits again.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_run_q <= 1'b0;
        end else if (!run_q[RUN_NOW_BIT]) begin
            act_run_q <= 1'b0;
        end else if (vsync) begin
            act_run_q <= run_q[RUN_NOW_BIT] && run_q[RUN_FRAME_BIT];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_bits
        assign prot[w] = gate_q[prot_pos(w)];
        assign chen[w] = gate_q[chen_pos(w)];
    end

    assign video_run = act_run_q && run_q[RUN_NOW_BIT];
    assign gate_word = DATA_W'(gate_q);
    assign run_word  = DATA_W'(run_q);
endmodule

// File: rtl/sb_read_mux.sv
module sb_read_mux
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN      = 5,
    parameter int REGS_PER_WIN = 4,
    parameter int DATA_W       = 32
) (
    input  addr_dec_t                                dec,
    input  logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0]   front_flat,
    input  logic [DATA_W-1:0]                        gate_word,
    input  logic [DATA_W-1:0]                        run_word,
    output logic [DATA_W-1:0]                        rdata
);
    localparam int SLOTS = NUM_WIN * REGS_PER_WIN;

    always_comb begin
        rdata = '0;
        unique case (dec.kind)
            SEL_WIN: begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (int'(dec.win) * REGS_PER_WIN + int'(dec.idx) == s)
                        rdata = front_flat[s*DATA_W +: DATA_W];
                end
            end
            SEL_RUN:  rdata = run_word;
            SEL_GATE: rdata = gate_word;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import shadow_bank_pkg::*;
#(
    parameter  int NUM_WIN      = 5,
    parameter  int REGS_PER_WIN = 4,
    parameter  int DATA_W       = 32,
    localparam int ADDR_W       = $clog2(NUM_WIN*REGS_PER_WIN + 2),
    localparam int ALL_W        = NUM_WIN*REGS_PER_WIN*DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              vsync,
    output logic [ALL_W-1:0]  act_regs,
    output logic [NUM_WIN-1:0] win_protect,
    output logic [NUM_WIN-1:0] win_chan_en,
    output logic              video_run
);
    localparam int IDX_W  = (REGS_PER_WIN > 1) ? $clog2(REGS_PER_WIN) : 1;
    localparam int WIN_W  = REGS_PER_WIN * DATA_W;
    localparam int GATE_W = 2 * NUM_WIN;

    addr_dec_t         dec;
    logic [ALL_W-1:0]  front_flat;
    logic [DATA_W-1:0] gate_word;
    logic [DATA_W-1:0] run_word;
    logic              gate_wr;
    logic              run_wr;

    sb_addr_decode #(
        .NUM_WIN      (NUM_WIN),
        .REGS_PER_WIN (REGS_PER_WIN),
        .ADDR_W       (ADDR_W)
    ) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign gate_wr = wr_en && (dec.kind == SEL_GATE);
    assign run_wr  = wr_en && (dec.kind == SEL_RUN);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit;
        assign hit = wr_en && (dec.kind == SEL_WIN) && (dec.win == 8'(w));

        sb_window_slot #(
            .REGS   (REGS_PER_WIN),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (hit),
            .wr_idx   (dec.idx[IDX_W-1:0]),
            .wdata    (wdata),
            .vsync    (vsync),
            .protect  (win_protect[w]),
            .front_o  (front_flat[w*WIN_W +: WIN_W]),
            .active_o (act_regs[w*WIN_W +: WIN_W])
        );
    end

    sb_gate_ctrl #(
        .NUM_WIN (NUM_WIN),
        .DATA_W  (DATA_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .gate_wr    (gate_wr),
        .gate_wdata (wdata[GATE_W-1:0]),
        .run_wr     (run_wr),
        .run_wdata  (wdata[1:0]),
        .vsync      (vsync),
        .prot       (win_protect),
        .chen       (win_chan_en),
        .video_run  (video_run),
        .gate_word  (gate_word),
        .run_word   (run_word)
    );

    sb_read_mux #(
        .NUM_WIN      (NUM_WIN),
        .REGS_PER_WIN (REGS_PER_WIN),
        .DATA_W       (DATA_W)
    ) u_rd (
        .dec        (dec),
        .front_flat (front_flat),
        .gate_word  (gate_word),
        .run_word   (run_word),
        .rdata      (rdata)
    );
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
    parameter int NUM_WIN      = 5,
    parameter int REGS_PER_WIN = 4,
    parameter int DATA_W       = 32
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   vsync,
    input logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] act_regs,
    input logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] front_flat,
    input logic [NUM_WIN-1:0]                     win_protect,
    input logic                                   video_run
);
    localparam int WIN_W = REGS_PER_WIN * DATA_W;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (act_regs == '0 && win_protect == '0 && !video_run)); // R1

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> $stable(act_regs)); // R2

    AST_RUN_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(video_run) |-> $past(vsync)); // R8

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_chk
        AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (vsync && win_protect[w]) |=> $stable(act_regs[w*WIN_W +: WIN_W])); // R4

        AST_OPEN_XFER: assert property (@(posedge clk) disable iff (rst)
            (vsync && !win_protect[w]) |=>
                (act_regs[w*WIN_W +: WIN_W] == $past(front_flat[w*WIN_W +: WIN_W]))); // R3
    end
endmodule

bind shadow_bank shadow_bank_chk #(
    .NUM_WIN      (NUM_WIN),
    .REGS_PER_WIN (REGS_PER_WIN),
    .DATA_W       (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vsync       (vsync),
    .act_regs    (act_regs),
    .front_flat  (front_flat),
    .win_protect (win_protect),
    .video_run   (video_run)
);

// File: tb/test_shadow_bank.sv
module test_shadow_bank;
    localparam int NW = 5;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int RUN_A  = NW*NR;
    localparam int GATE_A = NW*NR + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     addr = '0;
    logic              wr_en = 1'b0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              vsync = 1'b0;
    logic [NW*NR*DW-1:0] act_regs;
    logic [NW-1:0]     win_protect;
    logic [NW-1:0]     win_chan_en;
    logic              video_run;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] m_front [NW][NR];
    logic [DW-1:0] m_act   [NW][NR];
    logic [2*NW-1:0] m_gate;
    logic m_now, m_frame, m_act_run;

    always #4 clk = ~clk;

    shadow_bank i_shadow_bank (
        .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .wdata (wdata),
        .rdata (rdata), .vsync (vsync), .act_regs (act_regs),
        .win_protect (win_protect), .win_chan_en (win_chan_en), .video_run (video_run)
    );

    function automatic logic [DW-1:0] pat(input int w, input int i, input int k);
        return 32'h9E3779B9 * 32'(w*7 + i*3 + k*29 + 1) ^ 32'(k << 8);
    endfunction

    function automatic logic [DW-1:0] exp_read(input int a);
        if (a < NW*NR) return m_front[a/NR][a%NR];
        if (a == RUN_A) return {30'b0, m_frame, m_now};
        if (a == GATE_A) return DW'(m_gate);
        return '0;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < NR; i++) begin
                m_front[w][i] = '0;
                m_act[w][i] = '0;
            end
        m_gate = '0; m_now = 0; m_frame = 0; m_act_run = 0;
    endtask

    task automatic step(input bit wr, input int a, input logic [DW-1:0] d, input bit vs);
        @(negedge clk);
        wr_en = wr; addr = AW'(a); wdata = d; vsync = vs;
        @(posedge clk);
        if (vs)
            for (int w = 0; w < NW; w++)
                if (!m_gate[2*w])
                    for (int i = 0; i < NR; i++) m_act[w][i] = m_front[w][i];
        if (!m_now) m_act_run = 0;
        else if (vs) m_act_run = m_now & m_frame;
        if (wr) begin
            if (a < NW*NR) m_front[a/NR][a%NR] = d;
            else if (a == RUN_A) begin m_now = d[0]; m_frame = d[1]; end
            else if (a == GATE_A) m_gate = d[2*NW-1:0];
        end
        #1;
        wr_en = 0; vsync = 0;
        #1;
    endtask

    task automatic chk_out(input string tag);
        logic [NW*NR*DW-1:0] e_act;
        logic [NW-1:0] e_p, e_c;
        logic e_run;
        for (int w = 0; w < NW; w++) begin
            for (int i = 0; i < NR; i++) e_act[(w*NR+i)*DW +: DW] = m_act[w][i];
            e_p[w] = m_gate[2*w];
            e_c[w] = m_gate[2*w+1];
        end
        e_run = m_act_run & m_now;
        n_chk++;
        if (act_regs !== e_act || win_protect !== e_p || win_chan_en !== e_c || video_run !== e_run) begin
            n_bad++;
            $display("FAIL %s: act=%h prot=%b chen=%b run=%b expected act=%h prot=%b chen=%b run=%b",
                     tag, act_regs, win_protect, win_chan_en, video_run, e_act, e_p, e_c, e_run);
        end
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [DW-1:0] e;
        addr = AW'(a);
        #1;
        e = exp_read(a);
        n_chk++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rdata, e);
        end
    endtask

    task automatic write_all(input int k);
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < NR; i++) step(1, w*NR+i, pat(w, i, k), 0);
    endtask

    initial begin
        #1_600_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1: reset state
        chk_out("R1");
        for (int a = 0; a < 32; a++) rd_chk(a, "R1");

        // R2 / R6: front written, active untouched, reads show front
        write_all(1);
        chk_out("R2");
        for (int a = 0; a < NW*NR; a++) rd_chk(a, "R6");

        // R3: open transfer
        step(0, 0, '0, 1);
        chk_out("R3");

        // R5: protect windows 1 and 3, channel enable windows 0 and 4
        step(1, GATE_A, 32'h246, 0);
        chk_out("R5");
        rd_chk(GATE_A, "R5");
        step(0, 0, '0, 1);
        chk_out("R5");

        // R4: held windows keep values until protect is cleared
        write_all(2);
        step(0, 0, '0, 1);
        chk_out("R4");
        step(1, GATE_A, 32'h0, 0);
        chk_out("R4");
        step(0, 0, '0, 1);
        chk_out("R4");

        // R5: protect set in same cycle as vsync uses the old value
        step(1, 5, 32'hA5A5_0001, 0);
        step(1, GATE_A, 32'h004, 1);
        chk_out("R5");

        // R7: write and vsync together
        step(1, GATE_A, 32'h0, 0);
        step(1, 9, 32'hDEAD_BEEF, 1);
        chk_out("R7");
        step(0, 0, '0, 1);
        chk_out("R7");

        // R8: run control
        step(1, RUN_A, 32'h2, 0);
        step(0, 0, '0, 1);
        chk_out("R8");
        step(1, RUN_A, 32'h3, 0);
        chk_out("R8");
        rd_chk(RUN_A, "R8");
        step(0, 0, '0, 1);
        chk_out("R8");
        step(1, RUN_A, 32'h2, 0);
        chk_out("R8");
        step(1, RUN_A, 32'h3, 0);
        chk_out("R8");
        step(0, 0, '0, 1);
        chk_out("R8");
        step(1, RUN_A, 32'h1, 0);
        chk_out("R8");
        step(0, 0, '0, 1);
        chk_out("R8");

        // R9: unmapped addresses
        for (int a = GATE_A + 1; a < 32; a++) step(1, a, 32'hFFFF_FFFF, 0);
        chk_out("R9");
        for (int a = 0; a < 32; a++) rd_chk(a, "R9");

        // R3 / R4 sweep over every protect mask
        for (int m = 0; m < 32; m++) begin
            logic [2*NW-1:0] g;
            g = '0;
            for (int w = 0; w < NW; w++) g[2*w] = m[w];
            step(1, GATE_A, DW'(g), 0);
            write_all(10 + m);
            step(0, 0, '0, 1);
            chk_out(m[0] ? "R4" : "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule